// File: doc/BRIEF.md
# SIMT Divergence Lane Mask Unit

This unit keeps the active-lane mask of one 32-lane SIMT warp while the warp walks through nested if/then/else constructs. The condition for every lane is evaluated elsewhere and presented as a vector. Three strobes tell the unit that the warp enters the then side, switches to the else side, or leaves the construct. Both sides run one after the other under complementary masks, so the construct costs the then time plus the else time. The unit never speculates and never jumps.

On an if strobe, the current mask is saved on a stack and lanes with a false condition are switched off. On an else strobe, the selection is inverted relative to the mask saved at entry. Lanes that were already idle before the if therefore stay idle on both sides. On an end-if strobe, the saved mask is restored. A flag reports a side with no active lanes, so the control unit can skip that side. A one-cycle error pulse marks stack overflow or underflow.

Top module: `simt_lane_mask`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mask_o` is all ones, `side_empty_o` is 0, `err_o` is 0 and the stack holds no entries.
- R2: An accepted if strobe pushes the current mask and sets `mask_o` to old mask AND `cond_i` on the next clock edge.
- R3: An accepted else strobe sets `mask_o` to (top-of-stack entry mask) AND NOT (current mask). Lanes that were inactive at entry stay inactive.
- R4: An accepted end-if strobe pops the stack and restores `mask_o` to the entry mask that was saved by the matching if.
- R5: Constructs can be nested up to `DEPTH` levels, and each level is restored in last-in, first-out order.
- R6: An if strobe with `DEPTH` entries already stored raises `err_o` for one cycle and leaves the mask and the stack unchanged.
- R7: An else or end-if strobe with an empty stack raises `err_o` for one cycle and leaves the mask and the stack unchanged.
- R8: `side_empty_o` is 1 exactly when `mask_o` is all zeros. It is registered in the same cycle as the mask.
- R9: When several strobes are high in one cycle, only one of them acts. The priority is if, then else, then end-if, and the lower strobes are ignored.
- R10: `err_o` is a one-cycle pulse. It returns to 0 in any cycle that follows a cycle with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | LANES | Per-lane branch condition |
| if_i | input | 1 | Enter then side |
| else_i | input | 1 | Switch to else side |
| endif_i | input | 1 | Leave construct |
| mask_o | output | LANES | Registered active-lane mask |
| side_empty_o | output | 1 | Current mask has no active lane |
| err_o | output | 1 | Stack overflow or underflow pulse |

## Verification
Two events can fall in the same cycle. The first is several strobes at once, where priority decides which strobe acts. The second is a strobe that meets a full or empty stack, where the error path must win over the mask update. The bench provokes both cases directly: it raises if together with else and end-if, it pushes past `DEPTH`, and it pops an empty stack. A random phase then mixes all strobes at once. A behavioural queue model predicts mask, empty flag and error after every edge, and each output is compared against that prediction.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_FLIP = 2'd2,
    OP_POP  = 2'd3
  } lm_op_e;
endpackage

// File: rtl/lm_decode.sv
module lm_decode
  import lm_pkg::*;
(
  input  logic   if_i,
  input  logic   else_i,
  input  logic   endif_i,
  input  logic   full_i,
  input  logic   empty_i,
  output lm_op_e op_o,
  output logic   err_o
);
  always_comb begin
    op_o  = OP_NONE;
    err_o = 1'b0;
    if (if_i) begin
      if (full_i) err_o = 1'b1;
      else        op_o  = OP_PUSH;
    end else if (else_i) begin
      if (empty_i) err_o = 1'b1;
      else         op_o  = OP_FLIP;
    end else if (endif_i) begin
      if (empty_i) err_o = 1'b1;
      else         op_o  = OP_POP;
    end
  end
endmodule

// File: rtl/lm_stack.sv
module lm_stack #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (push_i) mem[AW'(cnt)] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (push_i) cnt <= cnt + 1'b1;
    else if (pop_i)  cnt <= cnt - 1'b1;
  end

  assign top_o   = mem[AW'(cnt - 1'b1)];
  assign full_o  = (cnt == FULL_CNT);
  assign empty_o = (cnt == '0);

  // R5
  depth_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |=> cnt == $past(cnt) + 1'b1);
  // R4
  pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/simt_lane_mask.sv
module simt_lane_mask
  import lm_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] cond_i,
  input  logic             if_i,
  input  logic             else_i,
  input  logic             endif_i,
  output logic [LANES-1:0] mask_o,
  output logic             side_empty_o,
  output logic             err_o
);
  lm_op_e           op;
  logic             dec_err, full, empty;
  logic [LANES-1:0] top_mask, mask_q, mask_d;
  logic             empty_q, err_q;

  lm_decode u_dec (
    .if_i(if_i), .else_i(else_i), .endif_i(endif_i),
    .full_i(full), .empty_i(empty), .op_o(op), .err_o(dec_err)
  );

  lm_stack #(.WIDTH(LANES), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst),
    .push_i(op == OP_PUSH), .pop_i(op == OP_POP),
    .wdata_i(mask_q), .top_o(top_mask),
    .full_o(full), .empty_o(empty)
  );

  always_comb begin
    unique case (op)
      OP_PUSH: mask_d = mask_q & cond_i;
      OP_FLIP: mask_d = top_mask & ~mask_q;
      OP_POP:  mask_d = top_mask;
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      empty_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      empty_q <= (mask_d == '0);
      err_q   <= dec_err;
    end
  end

  assign mask_o       = mask_q;
  assign side_empty_o = empty_q;
  assign err_o        = err_q;

  // R2
  then_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (if_i && !full) |=> (mask_q & ~$past(mask_q)) == '0);
  // R6
  overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (if_i && full) |=> err_q && $stable(mask_q));
  // R7
  underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!if_i && (else_i || endif_i) && empty) |=> err_q && $stable(mask_q));
  // R8
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    side_empty_o == (mask_o == '0));
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(if_i || else_i || endif_i) |=> !err_q);
endmodule

// File: tb/sim_simt_lane_mask.sv
module sim_simt_lane_mask;
  localparam int LANES = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0] cond_i = '0;
  logic if_i = 1'b0, else_i = 1'b0, endif_i = 1'b0;
  logic [LANES-1:0] mask_o;
  logic side_empty_o, err_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk[$];
  logic m_err;

  simt_lane_mask #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cond_i(cond_i), .if_i(if_i), .else_i(else_i),
    .endif_i(endif_i), .mask_o(mask_o), .side_empty_o(side_empty_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  task automatic compare(string req);
    total++;
    if (mask_o !== m_mask) begin
      bad++; $display("FAIL %s mask act=%h exp=%h", req, mask_o, m_mask);
    end
    total++;
    if (side_empty_o !== (m_mask == '0)) begin
      bad++; $display("FAIL %s empty act=%b exp=%b", req, side_empty_o, m_mask == '0);
    end
    total++;
    if (err_o !== m_err) begin
      bad++; $display("FAIL %s err act=%b exp=%b", req, err_o, m_err);
    end
  endtask

  task automatic step(logic fi, logic fe, logic fx, logic [LANES-1:0] c, string req);
    @(negedge clk);
    if_i = fi; else_i = fe; endif_i = fx; cond_i = c;
    m_err = 1'b0;
    if (fi) begin
      if (m_stk.size() == DEPTH) m_err = 1'b1;
      else begin m_stk.push_back(m_mask); m_mask = m_mask & c; end
    end else if (fe) begin
      if (m_stk.size() == 0) m_err = 1'b1;
      else m_mask = m_stk[$] & ~m_mask;
    end else if (fx) begin
      if (m_stk.size() == 0) m_err = 1'b1;
      else m_mask = m_stk.pop_back();
    end
    @(posedge clk); #1;
    compare(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_mask = '1; m_err = 1'b0;
    repeat (3) @(posedge clk);
    #1; compare("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; compare("R1");

    step(1, 0, 0, 32'h0000_FFFF, "R2");
    step(0, 1, 0, 32'h0, "R3");
    step(0, 0, 1, 32'h0, "R4");

    step(1, 0, 0, 32'h00FF_00FF, "R2");
    step(1, 0, 0, 32'h0F0F_0F0F, "R5");
    step(0, 1, 0, 32'h0, "R3");
    step(0, 0, 1, 32'h0, "R5");
    step(0, 1, 0, 32'h0, "R3");
    step(0, 0, 1, 32'h0, "R4");

    step(1, 0, 0, 32'h0, "R8");
    step(0, 1, 0, 32'h0, "R8");
    step(0, 0, 1, 32'h0, "R8");

    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 32'hFFFF_FFFE << i, "R5");
    step(1, 0, 0, 32'h0, "R6");
    step(0, 0, 0, 32'h0, "R10");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 32'h0, "R5");
    step(0, 0, 1, 32'h0, "R7");
    step(0, 1, 0, 32'h0, "R7");
    step(0, 0, 0, 32'h0, "R10");

    step(1, 1, 1, 32'hAAAA_AAAA, "R9");
    step(0, 1, 1, 32'h0, "R9");
    step(0, 0, 1, 32'h0, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      step(s[0], s[1], s[2], $urandom, "R9");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule